// File: doc/BRIEF.md
# Serial Line Break Detector

This block sits beside an asynchronous serial receiver and recognises line-break conditions. The receiver supplies one sample strobe per frame bit (data, optional parity, stop) with the first data sample marked, plus the 16x oversampling tick. A frame whose every sample is low marks the start of a break. The break ends once the line has been high for long enough: two consecutive high oversampling ticks in asynchronous mode, or a single high tick in synchronous mode.

Both the start and the end of a break set the same sticky status bit and produce a one-cycle event pulse, so software sees two events per break. The status bit stays set until a write-1 clear strobe. An interrupt output follows the status bit gated by a mask bit. A frame that breaks, and any frame that arrives while the line is in break, is flagged so the receiver can discard it without raising a framing error.

Top module: `brk_detect`

## Requirements
- R1: A break starts only when, in one frame, all `data_bits_i` data samples, the parity sample (when `par_en_i` is 1) and the stop sample are low. The frame is `data_bits_i + par_en_i + 1` samples long and its first sample comes with `frm_first_i` = 1. A single high sample in the frame prevents the start.
- R2: The break start takes effect at the clock edge that takes the stop sample. From the next cycle `brk_sta_o` and `brk_active_o` are 1, and `brk_evt_o` is 1 for exactly that one cycle.
- R3: With `sync_mode_i` = 0, a break ends on the second consecutive `os_tick_i` that finds `rx_i` high.
- R4: With `sync_mode_i` = 1, a break ends on the first `os_tick_i` that finds `rx_i` high.
- R5: An end of break clears `brk_active_o`, sets `brk_sta_o` again and pulses `brk_evt_o` for one cycle, in the cycle after the qualifying tick.
- R6: `brk_irq_o` is 1 exactly when `brk_sta_o` is 1 and `brk_ie_i` is 1.
- R7: `brk_sta_o` stays set until a cycle with `rst_sta_i` = 1 clears it. A break event in that same cycle takes priority, and the bit stays 1.
- R8: While `brk_active_o` is 1, an all-low frame raises no further break event and does not set `brk_sta_o`.
- R9: In asynchronous mode, a tick that finds `rx_i` low restarts the high-time count, so high ticks separated by a low tick do not end a break.
- R10: `frame_drop_o` is 1 during the stop-sample cycle of a frame that starts a break, or of any frame received while `brk_active_o` is 1. It is 0 for other frames, including a frame that has low data and a high stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Receive line level |
| os_tick_i | input | 1 | Oversampling tick (bit clock sample in synchronous mode) |
| samp_i | input | 1 | Frame bit sample strobe from the receiver |
| frm_first_i | input | 1 | Marks the first data sample of a frame |
| sync_mode_i | input | 1 | 1 selects synchronous operation |
| data_bits_i | input | 4 | Data bits per frame |
| par_en_i | input | 1 | Parity bit present |
| rst_sta_i | input | 1 | Write-1 clear of the status bit |
| brk_ie_i | input | 1 | Interrupt mask for break events |
| brk_sta_o | output | 1 | Sticky break status |
| brk_evt_o | output | 1 | One-cycle break event pulse |
| brk_irq_o | output | 1 | Masked interrupt request |
| brk_active_o | output | 1 | Line currently in break |
| frame_drop_o | output | 1 | Discard the frame at this stop sample |

## Verification
A break event that sets the status bit and a software clear of that bit can arrive in the same cycle. The bench provokes this by driving `rst_sta_i` together with the second high tick that ends an asynchronous break. It then judges that `brk_sta_o` stays 1 and that the scoreboard receives the end event. A lone clear afterwards must bring the bit to 0. This shows that the set was not lost and that the clear still works.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } line_mode_e;

  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_START = 2'd1,
    EVT_END   = 2'd2
  } brk_evt_e;
endpackage

// File: rtl/brk_frame_mon.sv
module brk_frame_mon #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             samp_i,
  input  logic             first_i,
  input  logic             rx_i,
  input  logic [LEN_W-1:0] frame_len_i,
  output logic             stop_o,
  output logic             all_low_o
);
  localparam logic [LEN_W-1:0] IDX_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] IDX_ONE = LEN_W'(1);

  logic [LEN_W-1:0] idx_q, idx_n;
  logic             low_q, low_n;

  always_comb begin
    if (first_i)              idx_n = IDX_ONE;
    else if (idx_q == IDX_MAX) idx_n = idx_q;
    else                      idx_n = idx_q + IDX_ONE;
    low_n = (first_i | low_q) & ~rx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      low_q <= 1'b0;
    end else if (samp_i) begin
      idx_q <= idx_n;
      low_q <= low_n;
    end
  end

  assign stop_o    = samp_i & (idx_n == frame_len_i);
  assign all_low_o = low_n;
endmodule

// File: rtl/brk_end_qual.sv
module brk_end_qual #(
  parameter int ASYNC_TICKS = 2,
  parameter int SYNC_TICKS  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  input  logic rx_i,
  input  logic sync_i,
  output logic end_o
);
  import brk_pkg::*;

  localparam int MAX_TICKS = (ASYNC_TICKS > SYNC_TICKS) ? ASYNC_TICKS : SYNC_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] THR_A = CNT_W'(ASYNC_TICKS);
  localparam logic [CNT_W-1:0] THR_S = CNT_W'(SYNC_TICKS);

  logic [CNT_W-1:0] hcnt_q, hcnt_n, thr;

  assign thr    = (line_mode_e'(sync_i) == MODE_SYNC) ? THR_S : THR_A;
  assign hcnt_n = hcnt_q + CNT_W'(1);
  assign end_o  = arm_i & tick_i & rx_i & (hcnt_n >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hcnt_q <= '0;
    else if (!arm_i)           hcnt_q <= '0;
    else if (tick_i) begin
      if (!rx_i)               hcnt_q <= '0;   // low sample restarts high time
      else if (!end_o)         hcnt_q <= hcnt_n;
      else                     hcnt_q <= '0;
    end
  end
endmodule

// File: rtl/brk_status.sv
module brk_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic sta_o,
  output logic evt_o,
  output logic active_o,
  output logic irq_o
);
  logic sta_q, evt_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_q <= 1'b0;
      evt_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      evt_q <= start_i | end_i;
      if (start_i)    act_q <= 1'b1;
      else if (end_i) act_q <= 1'b0;
      if (start_i | end_i) sta_q <= 1'b1;  // set beats clear
      else if (clr_i)      sta_q <= 1'b0;
    end
  end

  assign sta_o    = sta_q;
  assign evt_o    = evt_q;
  assign active_o = act_q;
  assign irq_o    = sta_q & ie_i;
endmodule

// File: rtl/brk_detect.sv
module brk_detect #(
  parameter int MAX_DATA_BITS   = 9,
  parameter int ASYNC_END_TICKS = 2,
  parameter int SYNC_END_TICKS  = 1,
  localparam int DB_W  = $clog2(MAX_DATA_BITS + 1),
  localparam int LEN_W = $clog2(MAX_DATA_BITS + 3)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_i,
  input  logic            os_tick_i,
  input  logic            samp_i,
  input  logic            frm_first_i,
  input  logic            sync_mode_i,
  input  logic [DB_W-1:0] data_bits_i,
  input  logic            par_en_i,
  input  logic            rst_sta_i,
  input  logic            brk_ie_i,
  output logic            brk_sta_o,
  output logic            brk_evt_o,
  output logic            brk_irq_o,
  output logic            brk_active_o,
  output logic            frame_drop_o
);
  logic [LEN_W-1:0] frame_len;
  logic stop_hit, all_low, brk_start, brk_end;

  assign frame_len = LEN_W'(data_bits_i) + LEN_W'(par_en_i) + LEN_W'(1);

  brk_frame_mon #(.LEN_W(LEN_W)) u_fmon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .samp_i      (samp_i),
    .first_i     (frm_first_i),
    .rx_i        (rx_i),
    .frame_len_i (frame_len),
    .stop_o      (stop_hit),
    .all_low_o   (all_low)
  );

  assign brk_start    = stop_hit & all_low & ~brk_active_o;
  assign frame_drop_o = stop_hit & (all_low | brk_active_o);

  brk_end_qual #(
    .ASYNC_TICKS (ASYNC_END_TICKS),
    .SYNC_TICKS  (SYNC_END_TICKS)
  ) u_endq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (brk_active_o),
    .tick_i (os_tick_i),
    .rx_i   (rx_i),
    .sync_i (sync_mode_i),
    .end_o  (brk_end)
  );

  brk_status u_sta (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (brk_start),
    .end_i    (brk_end),
    .clr_i    (rst_sta_i),
    .ie_i     (brk_ie_i),
    .sta_o    (brk_sta_o),
    .evt_o    (brk_evt_o),
    .active_o (brk_active_o),
    .irq_o    (brk_irq_o)
  );
endmodule

// File: rtl/brk_detect_chk.sv
module brk_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_i,
  input logic os_tick_i,
  input logic sync_mode_i,
  input logic rst_sta_i,
  input logic brk_ie_i,
  input logic brk_sta_o,
  input logic brk_evt_o,
  input logic brk_irq_o,
  input logic brk_active_o
);
  AST_EVT_SETS_STA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_evt_o |-> brk_sta_o); // R2
  AST_ACTIVE_RISE_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_active_o) |-> brk_evt_o); // R2
  AST_ACTIVE_FALL_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_active_o) |-> (brk_evt_o && brk_sta_o)); // R5
  AST_SYNC_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_active_o && sync_mode_i && os_tick_i && rx_i) |=> !brk_active_o); // R4
  AST_LOW_KEEPS_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_active_o && os_tick_i && !rx_i) |=> brk_active_o); // R9
  AST_STA_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_sta_o && !rst_sta_i) |=> brk_sta_o); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_ie_i |-> !brk_irq_o); // R6
  AST_IRQ_NEEDS_STA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_irq_o |-> brk_sta_o); // R6
endmodule

bind brk_detect brk_detect_chk u_chk (.*);

// File: tb/sim_brk_detect.sv
module sim_brk_detect;
  import brk_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, os_tick = 1'b0, samp = 1'b0, first = 1'b0;
  logic sync_mode = 1'b0, par_en = 1'b0, rst_sta = 1'b0, ie = 1'b0;
  logic [3:0] data_bits = 4'd8;
  logic sta, evt, irq, active, drop;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  brk_evt_e exp_q[$];
  bit m_active = 0;
  int m_hcnt = 0;

  always #4 clk = ~clk;

  brk_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .os_tick_i(os_tick),
    .samp_i(samp), .frm_first_i(first), .sync_mode_i(sync_mode),
    .data_bits_i(data_bits), .par_en_i(par_en), .rst_sta_i(rst_sta),
    .brk_ie_i(ie), .brk_sta_o(sta), .brk_evt_o(evt), .brk_irq_o(irq),
    .brk_active_o(active), .frame_drop_o(drop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop the expected event kind whenever a pulse appears
  always @(negedge clk) begin
    if (rst_n && evt) begin
      brk_evt_e got;
      got = active ? EVT_START : EVT_END;
      if (exp_q.size() == 0) chk(0, "R8 unexpected event", int'(got), int'(EVT_NONE));
      else begin
        brk_evt_e e;
        e = exp_q.pop_front();
        chk(got == e, "R2/R5 event kind", int'(got), int'(e));
      end
    end
  end

  task automatic send_frame(input logic [8:0] d, input logic p, input logic s, input string req);
    int n;
    bit low, exp_drop;
    n = int'(data_bits) + int'(par_en) + 1;
    low = 1;
    for (int i = 0; i < n; i++) begin
      logic b;
      if (i < int'(data_bits)) b = d[i];
      else if (par_en && i == int'(data_bits)) b = p;
      else b = s;
      low &= ~b;
      @(negedge clk);
      rx = b; samp = 1'b1; first = (i == 0);
      if (i == n - 1) begin
        exp_drop = low || m_active;
        if (low && !m_active) begin
          exp_q.push_back(EVT_START);
          m_active = 1; m_hcnt = 0;
        end
        #1 chk(drop == exp_drop, {req, " R10 drop"}, int'(drop), int'(exp_drop));
      end
    end
    @(negedge clk);
    samp = 1'b0; first = 1'b0; rx = 1'b1;
  endtask

  task automatic tick(input logic v, input logic clr);
    int thr;
    thr = sync_mode ? 1 : 2;
    @(negedge clk);
    rx = v; os_tick = 1'b1; rst_sta = clr;
    if (m_active) begin
      if (!v) m_hcnt = 0;
      else begin
        m_hcnt++;
        if (m_hcnt >= thr) begin
          exp_q.push_back(EVT_END);
          m_active = 0; m_hcnt = 0;
        end
      end
    end
    @(negedge clk);
    os_tick = 1'b0; rst_sta = 1'b0;
  endtask

  task automatic clear_sta();
    @(negedge clk); rst_sta = 1'b1;
    @(negedge clk); rst_sta = 1'b0;
  endtask

  task automatic expect_state(input bit s, input bit a, input string req);
    chk(sta == s, {req, " sta"}, int'(sta), int'(s));
    chk(active == a, {req, " active"}, int'(active), int'(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sta == 0 && evt == 0 && irq == 0 && active == 0, "R2 reset state", int'(sta), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: data low, stop high -> no break, no drop (R10)
    send_frame(9'h000, 1'b0, 1'b1, "R1 stop high");
    expect_state(0, 0, "R1 stop high");
    // R1: one data bit high
    send_frame(9'h010, 1'b0, 1'b0, "R1 data high");
    expect_state(0, 0, "R1 data high");
    // R1/R2: all low frame starts a break
    send_frame(9'h000, 1'b0, 1'b0, "R2 start");
    expect_state(1, 1, "R2 start");
    chk(irq == 0, "R6 masked", int'(irq), 0);
    @(negedge clk); ie = 1'b1; #1;
    chk(irq == 1, "R6 unmasked", int'(irq), 1);
    chk(evt == 0, "R2 single pulse", int'(evt), 0);

    // R7 clear, then R8 all-low frame in break gives nothing
    clear_sta();
    chk(sta == 0, "R7 clear", int'(sta), 0);
    chk(irq == 0, "R6 follows sta", int'(irq), 0);
    send_frame(9'h000, 1'b0, 1'b0, "R8 in break");
    expect_state(0, 1, "R8 in break");

    // R9: high, low, high does not end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b0);
    expect_state(0, 1, "R9 restart");
    tick(1'b1, 1'b0);
    expect_state(1, 0, "R3 R5 async end");
    clear_sta();

    // R1 with parity
    par_en = 1'b1;
    send_frame(9'h000, 1'b1, 1'b0, "R1 parity high");
    expect_state(0, 0, "R1 parity high");
    send_frame(9'h000, 1'b0, 1'b0, "R1 parity low");
    expect_state(1, 1, "R1 parity low");
    clear_sta();

    // R4 synchronous end on one high sample
    sync_mode = 1'b1;
    tick(1'b1, 1'b0);
    expect_state(1, 0, "R4 sync end");
    clear_sta();

    // short frame, async; collision of end and clear (R7)
    sync_mode = 1'b0; par_en = 1'b0; data_bits = 4'd5;
    send_frame(9'h000, 1'b0, 1'b0, "R1 short frame");
    expect_state(1, 1, "R1 short frame");
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    expect_state(1, 0, "R7 set beats clear");
    clear_sta();
    chk(sta == 0, "R7 lone clear", int'(sta), 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all events seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule